// File: doc/BRIEF.md
# CPU Effective Address Generator

This block forms the 16-bit effective address used by an 8-bit accumulator CPU for three operand addressing styles. In absolute (extended) mode, the address is made from the two operand bytes. In indexed mode, an unsigned byte offset is added to one of two 16-bit index registers. In relative mode, the block produces the next program counter for a conditional branch.

The branch condition is resolved upstream and arrives as a single flag. The index register choice also arrives already decoded: the flag is set when the instruction carried the Y-select prefix byte (0x18).

The computation takes one registered cycle. A request presented with `in_valid_i` high appears on the outputs on the next clock edge, together with a valid flag and the mode that was used. When no request is presented, the outputs keep their last result.

Top module: `ea_gen`

## Requirements
- R1: While `rst_ni` is low, and after its release before any request, `out_valid_o` is 0, `ea_o` is 0x0000 and `out_mode_o` is 0.
- R2: `out_valid_o` equals the value `in_valid_i` had at the previous rising clock edge.
- R3: With mode code 0 (absolute), the result is `{opnd0_i, opnd1_i}`, where `opnd0_i` is the high byte.
- R4: With mode code 1 (indexed) and `idx_y_i` = 0, the result is `ix_i` plus the zero-extended `opnd0_i`, modulo 2^16. `opnd1_i` has no effect.
- R5: With mode code 1 and `idx_y_i` = 1, the result is `iy_i` plus the zero-extended `opnd0_i`, modulo 2^16. `ix_i` has no effect.
- R6: With mode code 2 (relative) and `br_taken_i` = 1, the result is `pc_i` plus the sign-extended `opnd0_i`, modulo 2^16. Here `pc_i` is the address following the branch instruction.
- R7: With mode code 2 and `br_taken_i` = 0, the result is `pc_i`, whatever the offset.
- R8: Mode code 3 is reserved and yields `pc_i`.
- R9: `out_mode_o` carries the mode code of the request that produced the current result.
- R10: A cycle with `in_valid_i` = 0 leaves `ea_o` and `out_mode_o` unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present this cycle |
| mode_i | input | 2 | 0 absolute, 1 indexed, 2 relative, 3 reserved |
| opnd0_i | input | 8 | First operand byte (high byte, or offset) |
| opnd1_i | input | 8 | Second operand byte (low byte in absolute mode) |
| idx_y_i | input | 1 | 1 selects the Y index register (prefixed instruction) |
| ix_i | input | 16 | Index register X |
| iy_i | input | 16 | Index register Y |
| pc_i | input | 16 | Address after the branch instruction |
| br_taken_i | input | 1 | Resolved branch condition |
| out_valid_o | output | 1 | Result valid |
| out_mode_o | output | 2 | Mode code of the result |
| ea_o | output | 16 | Effective address or next program counter |

## Verification
Random requests cover all four mode codes with random index, counter and operand values. Because the unused inputs also vary randomly, the test can tell which operand byte and which index register each mode actually reads.

Directed cases target the places where a width or sign error would show:
- an index sum that wraps past 0xFFFF;
- a backward branch with offset 0x80 from a low counter;
- a forward branch with offset 0x7F from near the top of memory;
- a not-taken branch with a nonzero offset.

Idle cycles with changing inputs separate a result that is held from one that is recomputed.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    MODE_ABS = 2'd0,
    MODE_IDX = 2'd1,
    MODE_REL = 2'd2,
    MODE_RSV = 2'd3
  } ea_mode_e;
endpackage

// File: rtl/ea_idx_add.sv
module ea_idx_add #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              sel_y_i,
  input  logic [ADDR_W-1:0] ix_i,
  input  logic [ADDR_W-1:0] iy_i,
  input  logic [BYTE_W-1:0] ofs_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int unsigned PAD_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] base;

  assign base  = sel_y_i ? iy_i : ix_i;
  assign sum_o = base + {{PAD_W{1'b0}}, ofs_i};  // unsigned, wraps
endmodule

// File: rtl/ea_rel_add.sv
module ea_rel_add #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [BYTE_W-1:0] ofs_i,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam int unsigned PAD_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] ofs_ext;

  // Not taken gates the offset to zero rather than muxing a second path.
  assign ofs_ext   = taken_i ? {{PAD_W{ofs_i[BYTE_W-1]}}, ofs_i} : '0;
  assign next_pc_o = pc_i + ofs_ext;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        mode_i,
  input  logic [BYTE_W-1:0] opnd0_i,
  input  logic [BYTE_W-1:0] opnd1_i,
  input  logic              idx_y_i,
  input  logic [ADDR_W-1:0] ix_i,
  input  logic [ADDR_W-1:0] iy_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              br_taken_i,
  output logic              out_valid_o,
  output logic [1:0]        out_mode_o,
  output logic [ADDR_W-1:0] ea_o
);
  ea_mode_e          mode;
  logic [ADDR_W-1:0] idx_sum;
  logic [ADDR_W-1:0] rel_pc;
  logic [ADDR_W-1:0] ea_d;

  assign mode = ea_mode_e'(mode_i);

  ea_idx_add #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_idx (
    .sel_y_i (idx_y_i),
    .ix_i    (ix_i),
    .iy_i    (iy_i),
    .ofs_i   (opnd0_i),
    .sum_o   (idx_sum)
  );

  ea_rel_add #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_rel (
    .taken_i   (br_taken_i),
    .pc_i      (pc_i),
    .ofs_i     (opnd0_i),
    .next_pc_o (rel_pc)
  );

  always_comb begin
    unique case (mode)
      MODE_ABS: ea_d = {opnd0_i, opnd1_i};
      MODE_IDX: ea_d = idx_sum;
      MODE_REL: ea_d = rel_pc;
      default:  ea_d = pc_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_mode_o  <= 2'd0;
      ea_o        <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_mode_o <= mode_i;
        ea_o       <= ea_d;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [1:0]        mode_i,
  input logic [BYTE_W-1:0] opnd0_i,
  input logic [BYTE_W-1:0] opnd1_i,
  input logic              idx_y_i,
  input logic [ADDR_W-1:0] ix_i,
  input logic [ADDR_W-1:0] iy_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              br_taken_i,
  input logic              out_valid_o,
  input logic [1:0]        out_mode_o,
  input logic [ADDR_W-1:0] ea_o
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (!out_valid_o && ea_o == '0 && out_mode_o == 2'd0); // R1
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R2
  AST_VALID_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R2
  AST_ABS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 2'd0) |=> ea_o == $past({opnd0_i, opnd1_i})); // R3
  AST_IDX_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 2'd1 && !idx_y_i)
      |=> ea_o == $past(ix_i + ADDR_W'(opnd0_i))); // R4
  AST_IDX_Y: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 2'd1 && idx_y_i)
      |=> ea_o == $past(iy_i + ADDR_W'(opnd0_i))); // R5
  AST_REL_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 2'd2 && br_taken_i)
      |=> ea_o == $past(pc_i + ADDR_W'($signed(opnd0_i)))); // R6
  AST_REL_FALL_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 2'd2 && !br_taken_i) |=> ea_o == $past(pc_i)); // R7
  AST_RSV_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 2'd3) |=> ea_o == $past(pc_i)); // R8
  AST_MODE_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_mode_o == $past(mode_i)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(ea_o) && $stable(out_mode_o))); // R10
endmodule

bind ea_gen ea_gen_chk u_ea_gen_chk (.*);

// File: tb/ea_gen_bench.sv
`timescale 1ns/1ps
module ea_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [7:0]  opnd0_i = 8'h0;
  logic [7:0]  opnd1_i = 8'h0;
  logic        idx_y_i = 1'b0;
  logic [15:0] ix_i = 16'h0;
  logic [15:0] iy_i = 16'h0;
  logic [15:0] pc_i = 16'h0;
  logic        br_taken_i = 1'b0;
  logic        out_valid_o;
  logic [1:0]  out_mode_o;
  logic [15:0] ea_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ea_gen u_ea_gen (.*);

  function automatic logic [15:0] model_ea(
    input logic [1:0] m, input logic [7:0] b0, input logic [7:0] b1,
    input logic ysel, input logic [15:0] x, input logic [15:0] y,
    input logic [15:0] pc, input logic tk);
    logic [15:0] r;
    case (m)
      2'd0: r = {b0, b1};
      2'd1: r = (ysel ? y : x) + {8'h00, b0};
      2'd2: r = tk ? pc + {{8{b0[7]}}, b0} : pc;
      default: r = pc;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [7:0] b0, input logic [7:0] b1,
                       input logic ysel, input logic [15:0] x, input logic [15:0] y,
                       input logic [15:0] pc, input logic tk, input string req);
    logic [15:0] exp;
    @(negedge clk_i);
    in_valid_i = 1'b1; mode_i = m; opnd0_i = b0; opnd1_i = b1;
    idx_y_i = ysel; ix_i = x; iy_i = y; pc_i = pc; br_taken_i = tk;
    exp = model_ea(m, b0, b1, ysel, x, y, pc, tk);
    @(posedge clk_i); #1;
    check(req, {16'h0, ea_o}, {16'h0, exp});
    check("R9", {30'h0, out_mode_o}, {30'h0, m});
    check("R2", {31'h0, out_valid_o}, 32'h1);
  endtask

  initial begin
    #1;
    check("R1", {15'h0, out_valid_o, ea_o}, 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1", {13'h0, out_valid_o, out_mode_o, ea_o}, 32'h0);

    // directed corners
    apply(2'd0, 8'hA5, 8'h3C, 1'b0, 16'h1111, 16'h2222, 16'h3333, 1'b1, "R3");
    apply(2'd1, 8'hFF, 8'h77, 1'b0, 16'hFFFF, 16'h0100, 16'h0, 1'b0, "R4");
    apply(2'd1, 8'h80, 8'h01, 1'b1, 16'h5000, 16'hFFF0, 16'h0, 1'b0, "R5");
    apply(2'd2, 8'h80, 8'h00, 1'b0, 16'h0, 16'h0, 16'h0005, 1'b1, "R6");
    apply(2'd2, 8'h7F, 8'h00, 1'b1, 16'h0, 16'h0, 16'hFFF0, 1'b1, "R6");
    apply(2'd2, 8'h40, 8'h12, 1'b0, 16'h0, 16'h0, 16'h1234, 1'b0, "R7");
    apply(2'd3, 8'h22, 8'h33, 1'b1, 16'h4444, 16'h5555, 16'hBEEF, 1'b1, "R8");

    // idle cycle: inputs change, result holds
    @(negedge clk_i);
    in_valid_i = 1'b0; mode_i = 2'd0; opnd0_i = 8'h00; opnd1_i = 8'h00; pc_i = 16'h0;
    @(posedge clk_i); #1;
    check("R10", {14'h0, out_mode_o, ea_o}, {14'h0, 2'd3, 16'hBEEF});
    check("R2", {31'h0, out_valid_o}, 32'h0);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m;
      string tag;
      m = 2'($urandom_range(0, 3));
      case (m)
        2'd0: tag = "R3";
        2'd1: tag = "R4/R5";
        2'd2: tag = "R6/R7";
        default: tag = "R8";
      endcase
      apply(m, 8'($urandom), 8'($urandom), 1'($urandom), 16'($urandom),
            16'($urandom), 16'($urandom), 1'($urandom), tag);
      if (($urandom & 7) == 0) begin
        logic [15:0] held;
        logic [1:0]  hm;
        held = ea_o; hm = out_mode_o;
        @(negedge clk_i);
        in_valid_i = 1'b0; mode_i = 2'($urandom); opnd0_i = 8'($urandom);
        pc_i = 16'($urandom); ix_i = 16'($urandom);
        @(posedge clk_i); #1;
        check("R10", {14'h0, out_mode_o, ea_o}, {14'h0, hm, held});
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule